// File: doc/BRIEF.md
# Batch-Ranked Packet Scheduler

This block picks which of several competing input requests may use one output port of a network router. Every packet is stamped at injection with a batch number. The batch number is taken from a free-running epoch counter that advances once per fixed interval of cycles. When requests compete, the packet from the older batch always wins. Among packets of the same batch, an application ranking decides, and that ranking is the same for every router. Ties that remain go to the lowest input index.

The epoch counter lives inside the block and is exported, so that injecting agents can stamp new packets with its current value. Batch numbers are narrow and wrap. Age is therefore the modular distance from the current epoch back to the packet's stamp, which lets batch 7 count as older than batch 0 just after a wrap. The rank of each application is a small per-application value on a configuration input; a smaller value means higher priority. Every cycle with at least one live request produces exactly one grant, registered, in the following cycle.

Top module: `bsched_out_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, `grant` is all zero, `grant_valid` is low and `cur_batch` is 0.
- R2: `cur_batch` (3 bits) starts at 0 after reset, advances by one every INTERVAL (default 3) clock cycles, and wraps from 7 to 0.
- R3: One cycle after any `req_valid` bit is high, `grant_valid` is high and `grant` is one-hot on a lane that was requesting. One cycle after no bit is high, `grant_valid` is low and `grant` is zero.
- R4: A request whose age, (`cur_batch` - its batch) mod 8, is larger wins over one with a smaller age, whatever the ranks are.
- R5: Among requests of equal age, the one whose application has the smaller rank value wins. Application a's rank is `rank_cfg[a*2 +: 2]`. Lane i's application is `req_app[i*2 +: 2]` and its batch is `req_batch[i*3 +: 3]`.
- R6: Among requests with equal age and equal rank, the lowest input index wins.
- R7: Age is measured modulo the batch width: with `cur_batch` = 0, a batch-7 request is older than a batch-0 request.
- R8: A change on `rank_cfg` affects the next grant decision, with no reset or drain needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rank_cfg | input | NUM_APPS*2 | Per-application rank, smaller value is higher priority |
| req_valid | input | NUM_IN | One live request per input lane |
| req_app | input | NUM_IN*APP_W | Source application of each lane's packet |
| req_batch | input | NUM_IN*3 | Injection batch stamp of each lane's packet |
| cur_batch | output | 3 | Current epoch, used to stamp packets at injection |
| grant | output | NUM_IN | One-hot grant, one cycle after the decision inputs |
| grant_valid | output | 1 | High when `grant` carries a winner |

## Verification
A wrong phase or epoch value shows on `cur_batch` within one interval. It also makes an older packet lose to a fresher one on the next contended cycle, where it appears as a grant on the wrong lane. A bad age subtraction is only visible around the wrap, so one scenario waits until the epoch reads 0 and sets a batch-7 stamp against a batch-0 stamp. Rank or tie errors show one cycle after the contending requests are applied, because the grant is a single register away from the inputs.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    localparam int BATCH_W = 3;
    localparam int RANK_W  = 2;

    typedef logic [BATCH_W-1:0] batch_t;
    typedef logic [RANK_W-1:0]  rank_t;

    // Ordering key: a larger packed value means a more urgent request.
    typedef struct packed {
        logic   live;
        batch_t age;
        rank_t  urgency;
    } key_t;

    function automatic batch_t batch_age(batch_t now, batch_t stamp);
        return batch_t'(now - stamp);
    endfunction

    function automatic key_t make_key(logic live, batch_t now, batch_t stamp, rank_t rank);
        key_t k;
        k.live    = live;
        k.age     = live ? batch_age(now, stamp) : '0;
        k.urgency = live ? ~rank : '0;
        return k;
    endfunction

endpackage

// File: rtl/bsched_epoch.sv
module bsched_epoch
    import bsched_pkg::*;
#(
    parameter int INTERVAL = 3
) (
    input  logic   clk,
    input  logic   rst,
    output batch_t epoch
);
    localparam int PH_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INTERVAL - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            epoch <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
            epoch <= batch_t'(epoch + 1'b1);
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/bsched_keygen.sv
module bsched_keygen
    import bsched_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int NUM_APPS = 4,
    parameter int APP_W    = 2
) (
    input  batch_t                     now,
    input  logic [NUM_IN-1:0]          live,
    input  logic [NUM_IN*APP_W-1:0]    app,
    input  logic [NUM_IN*BATCH_W-1:0]  stamp,
    input  logic [NUM_APPS*RANK_W-1:0] rank_cfg,
    output key_t [NUM_IN-1:0]          keys
);
    for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
        logic [APP_W-1:0] lane_app;
        rank_t            lane_rank;
        assign lane_app  = app[g*APP_W +: APP_W];
        assign lane_rank = rank_cfg[int'(lane_app)*RANK_W +: RANK_W];
        assign keys[g]   = make_key(live[g], now, stamp[g*BATCH_W +: BATCH_W], lane_rank);
    end
endmodule

// File: rtl/bsched_pick.sv
module bsched_pick
    import bsched_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  key_t [NUM_IN-1:0] keys,
    output logic [NUM_IN-1:0] win,
    output logic              any
);
    key_t best;

    // Strict comparison while scanning upward keeps the lowest index on ties.
    always_comb begin
        best = '0;
        win  = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (keys[i] > best) begin
                best   = keys[i];
                win    = '0;
                win[i] = 1'b1;
            end
        end
        any = best.live;
    end
endmodule

// File: rtl/bsched_out_arbiter.sv
module bsched_out_arbiter
    import bsched_pkg::*;
#(
    parameter int NUM_IN   = 4,
    parameter int NUM_APPS = 4,
    parameter int INTERVAL = 3,
    localparam int APP_W   = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_APPS*RANK_W-1:0] rank_cfg,
    input  logic [NUM_IN-1:0]          req_valid,
    input  logic [NUM_IN*APP_W-1:0]    req_app,
    input  logic [NUM_IN*BATCH_W-1:0]  req_batch,
    output logic [BATCH_W-1:0]         cur_batch,
    output logic [NUM_IN-1:0]          grant,
    output logic                       grant_valid
);
    batch_t              epoch;
    key_t [NUM_IN-1:0]   keys;
    logic [NUM_IN-1:0]   win;
    logic                any;

    bsched_epoch #(.INTERVAL(INTERVAL)) u_epoch (
        .clk   (clk),
        .rst   (rst),
        .epoch (epoch)
    );

    bsched_keygen #(.NUM_IN(NUM_IN), .NUM_APPS(NUM_APPS), .APP_W(APP_W)) u_keygen (
        .now      (epoch),
        .live     (req_valid),
        .app      (req_app),
        .stamp    (req_batch),
        .rank_cfg (rank_cfg),
        .keys     (keys)
    );

    bsched_pick #(.NUM_IN(NUM_IN)) u_pick (
        .keys (keys),
        .win  (win),
        .any  (any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant       <= '0;
            grant_valid <= 1'b0;
        end else begin
            grant       <= win;
            grant_valid <= any;
        end
    end

    assign cur_batch = epoch;
endmodule

// File: rtl/bsched_out_arbiter_chk.sv
module bsched_out_arbiter_chk #(
    parameter int NUM_IN  = 4,
    parameter int BATCH_W = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_IN-1:0]         req_valid,
    input logic [NUM_IN*BATCH_W-1:0] req_batch,
    input logic [BATCH_W-1:0]        cur_batch,
    input logic [NUM_IN-1:0]         grant,
    input logic                      grant_valid
);
    logic [BATCH_W-1:0] lane_age [NUM_IN];

    for (genvar g = 0; g < NUM_IN; g++) begin : g_age
        assign lane_age[g] = BATCH_W'(cur_batch - req_batch[g*BATCH_W +: BATCH_W]);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (grant == '0 && !grant_valid && cur_batch == '0));

    // R2
    epoch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cur_batch != $past(cur_batch)) |->
        (cur_batch == BATCH_W'($past(cur_batch) + 1'b1)));

    // R3
    grant_live_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((grant & ~$past(req_valid)) == '0));

    // R3
    grant_when_asked_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (grant_valid == (|$past(req_valid))));

    // R3
    grant_shape_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid ? ($countones(grant) == 1) : (grant == '0));

    // R4
    for (genvar i = 0; i < NUM_IN; i++) begin : g_win
        for (genvar j = 0; j < NUM_IN; j++) begin : g_rival
            oldest_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && grant[i] && $past(req_valid[j])) |->
                ($past(lane_age[i]) >= $past(lane_age[j])));
        end
    end
endmodule

bind bsched_out_arbiter bsched_out_arbiter_chk #(
    .NUM_IN  (NUM_IN),
    .BATCH_W (bsched_pkg::BATCH_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_batch   (req_batch),
    .cur_batch   (cur_batch),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/bsched_out_arbiter_tb.sv
module bsched_out_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rank_cfg;
    logic [3:0] req_valid = '0;
    logic [7:0] req_app = '0;
    logic [11:0] req_batch = '0;
    logic [2:0] cur_batch;
    logic [3:0] grant;
    logic       grant_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bsched_out_arbiter u_dut (
        .clk(clk), .rst(rst), .rank_cfg(rank_cfg),
        .req_valid(req_valid), .req_app(req_app), .req_batch(req_batch),
        .cur_batch(cur_batch), .grant(grant), .grant_valid(grant_valid)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_lane(int lane, logic [1:0] app, logic [2:0] batch);
        req_valid[lane] = 1'b1;
        req_app[lane*2 +: 2] = app;
        req_batch[lane*3 +: 3] = batch;
    endtask

    task automatic clear_lanes();
        req_valid = '0;
        req_app = '0;
        req_batch = '0;
    endtask

    // One posedge between drive and sample, then sample at the following negedge.
    task automatic expect_grant(string tag, logic [3:0] exp_g, logic exp_v);
        @(negedge clk);
        check({tag, " grant"}, grant, exp_g);
        check({tag, " grant_valid"}, grant_valid, exp_v);
        clear_lanes();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 grant in reset", grant, 0);
        check("R1 grant_valid in reset", grant_valid, 0);
        check("R1 cur_batch in reset", cur_batch, 0);
        rst = 1'b0;
    endtask

    task automatic t_epoch();
        repeat (2) @(negedge clk);
        check("R1 grant after reset", grant, 0);
        check("R2 epoch after 2 cycles", cur_batch, 0);
        repeat (1) @(negedge clk);
        check("R2 epoch after 3 cycles", cur_batch, 1);
        repeat (18) @(negedge clk);
        check("R2 epoch after 21 cycles", cur_batch, 7);
        repeat (3) @(negedge clk);
        check("R2 epoch wraps after 24 cycles", cur_batch, 0);
    endtask

    task automatic t_idle();
        clear_lanes();
        expect_grant("R3 idle", 4'b0000, 1'b0);
    endtask

    task automatic t_single();
        set_lane(3, 2'd0, cur_batch);
        expect_grant("R3 single lane", 4'b1000, 1'b1);
        expect_grant("R3 dropped request", 4'b0000, 1'b0);
    endtask

    task automatic t_age();
        // lane0: best rank, current batch; lane2: worst rank, two batches older
        set_lane(0, 2'd1, cur_batch);
        set_lane(2, 2'd0, 3'(cur_batch - 3'd2));
        expect_grant("R4 older batch beats better rank", 4'b0100, 1'b1);
    endtask

    task automatic t_rank();
        set_lane(0, 2'd0, cur_batch);
        set_lane(1, 2'd2, cur_batch);
        set_lane(3, 2'd3, cur_batch);
        expect_grant("R5 lowest rank value in batch", 4'b1000, 1'b1);
    endtask

    task automatic t_tie();
        set_lane(2, 2'd1, cur_batch);
        set_lane(1, 2'd1, cur_batch);
        set_lane(3, 2'd1, cur_batch);
        expect_grant("R6 tie to lowest index", 4'b0010, 1'b1);
    endtask

    task automatic t_wrap();
        while (cur_batch != 3'd0) @(negedge clk);
        set_lane(0, 2'd1, 3'd0);
        set_lane(1, 2'd0, 3'd7);
        expect_grant("R7 batch 7 older than batch 0", 4'b0010, 1'b1);
    endtask

    task automatic t_rank_change();
        set_lane(0, 2'd0, cur_batch);
        set_lane(1, 2'd1, cur_batch);
        expect_grant("R8 default ranks", 4'b0010, 1'b1);
        rank_cfg = {2'd1, 2'd2, 2'd3, 2'd0};
        set_lane(0, 2'd0, cur_batch);
        set_lane(1, 2'd1, cur_batch);
        expect_grant("R8 swapped ranks", 4'b0001, 1'b1);
        rank_cfg = {2'd1, 2'd2, 2'd0, 2'd3};
    endtask

    initial begin
        // app3 rank1, app2 rank2, app1 rank0, app0 rank3
        rank_cfg = {2'd1, 2'd2, 2'd0, 2'd3};
        t_reset();
        t_epoch();
        t_idle();
        t_single();
        t_age();
        t_rank();
        t_tie();
        t_wrap();
        t_rank_change();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule